// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

This block sits between a processor and a flash array. Software reaches it through two buses. The register bus carries the key, status, control and address registers. The memory bus carries plain half-word reads and writes of the array. The array itself sits outside the block, behind a port with strobes and a completion pulse. The array is built from equal user pages plus one trailing information page.

After reset the control register is frozen. Software unlocks it by writing two keys in the right order. It can then do three things. It can program single half-words through the memory bus. It can erase one user page. It can erase all user pages in one command. The block sequences each operation and reports busy, success and two kinds of failure. Two interrupt lines can signal these results.

Both buses use valid/ready. The register bus never applies back-pressure, so `reg_ready` is always high. The memory bus holds `mem_ready` low while an operation runs. A read or write presented in that time waits, and the master must keep its request stable until `mem_ready` is high. A request is taken on the edge where `mem_valid` and `mem_ready` are both high.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset, the control register (offset 2) reads 0x0000_0080. That value has only the lock bit (bit 7) set. The status register (offset 1) reads 0 and both interrupt lines are low.
- R2: While the block is locked, writes to the control register have no effect. Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0) unlocks it. Writing a control word with bit 7 set locks it again, and unlocking then needs both keys once more.
- R3: A key with the wrong value, or a key written out of order, leaves the block locked until the next reset. This holds even if the correct pair is written afterwards.
- R4: With PG (control bit 0) set, an accepted memory-bus write starts a program operation. BSY (status bit 0) is high while the operation runs. EOP (status bit 5) is set only when the operation succeeds. The address register (offset 3) holds the half-word address of the last accepted program write.
- R5: Before programming, the block reads the target half-word. If the value is not 0xFFFF, it sets PGERR (status bit 2), does not program, and leaves the array unchanged.
- R6: A program write or page erase aimed at a write-protected user page (`page_wp` bit set) or at the information page sets WRPRTERR (status bit 4). The array is not changed, BSY does not rise and STRT stays low.
- R7: While BSY is high, `mem_ready` is low. A read issued during a program operation completes after the operation ends and returns the new value.
- R8: A control write with PER (bit 1) and STRT (bit 6) both set erases the page selected by the page field of the address register. Every half-word of that page becomes 0xFFFF and other pages are not changed. STRT reads 1 during the erase and 0 once BSY falls.
- R9: A control write with MER (bit 2) and STRT set erases every user page in ascending order. Write-protected user pages are erased too. The information page is left unchanged, and afterwards the address register holds the base address of the last user page.
- R10: Status bits 2, 4 and 5 clear when 1 is written to them. Writing 0 to a status bit leaves it unchanged.
- R11: `irq_eop` is high when EOP is set and EOPIE (control bit 12) is set. `irq_err` is high when ERRIE (control bit 10) is set and PGERR or WRPRTERR is set.
- R12: A memory-bus write made while PG is clear is accepted and ignored. The array is unchanged and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register bus request |
| reg_we | input | 1 | Register bus write (1) or read (0) |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Register bus ready (always high) |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_valid | input | 1 | Memory bus request |
| mem_we | input | 1 | Memory bus write (1) or read (0) |
| mem_addr | input | AW | Half-word address in the array |
| mem_wdata | input | 16 | Half-word to program |
| mem_ready | output | 1 | Memory bus ready, low while busy |
| mem_rdata | output | 16 | Read data, valid when the read is accepted |
| page_wp | input | PAGES | Write-protect flag, one per user page |
| arr_addr | output | AW | Array address |
| arr_wdata | output | 16 | Array program data |
| arr_prog | output | 1 | One-cycle program strobe |
| arr_erase | output | 1 | One-cycle erase strobe for the page holding `arr_addr` |
| arr_rdata | input | 16 | Array read data for `arr_addr`, combinational |
| arr_done | input | 1 | One-cycle pulse when the array finishes a strobe |
| irq_eop | output | 1 | End-of-operation interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a memory-bus read that arrives in the cycle after a program write is accepted. The read has to wait through the blank check and the array latency, and it must then return the value just written rather than the stale one. The stimulus issues the read straight after the write handshake, counts the cycles spent waiting, and checks both the wait and the data.

The second is the permanent lockout. The stimulus reaches it twice: once with a wrong key, and once with the right keys in the wrong order. In each case a correct pair follows and must fail to open the control register. Mass erase is driven with the first user page write-protected and preloaded with data. The stimulus then checks that this page is erased and that the information page is untouched.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam logic [1:0] RA_KEY  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_ADDR = 2'd3;

  // control bit positions
  localparam int CB_PG    = 0;
  localparam int CB_PER   = 1;
  localparam int CB_MER   = 2;
  localparam int CB_STRT  = 6;
  localparam int CB_LOCK  = 7;
  localparam int CB_ERRIE = 10;
  localparam int CB_EOPIE = 12;

  // status bit positions
  localparam int SB_BSY   = 0;
  localparam int SB_PGERR = 2;
  localparam int SB_WPERR = 4;
  localparam int SB_EOP   = 5;

  localparam logic [15:0] ERASED_HW = 16'hFFFF;

  typedef enum logic [1:0] {OP_IDLE, OP_CHECK, OP_ERASE, OP_WAIT} op_state_t;
  typedef enum logic [1:0] {KS_FIRST, KS_SECOND, KS_OPEN, KS_DEAD} key_state_t;
endpackage

// File: rtl/nvm_key_gate.sv
module nvm_key_gate
  import nvm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        locked
);
  key_state_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= KS_FIRST;
    end else begin
      unique case (st)
        KS_FIRST:  if (key_we) st <= (key_data == KEY_FIRST)  ? KS_SECOND : KS_DEAD;
        KS_SECOND: if (key_we) st <= (key_data == KEY_SECOND) ? KS_OPEN   : KS_DEAD;
        KS_OPEN:   if (relock) st <= KS_FIRST;
        default:   st <= KS_DEAD;
      endcase
    end
  end

  assign locked = (st != KS_OPEN);
endmodule

// File: rtl/nvm_w1c_flags.sv
module nvm_w1c_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f;
    always_ff @(posedge clk) begin
      if (!rst_n)         f <= 1'b0;
      else if (set_i[g])  f <= 1'b1;
      else if (clr_i[g])  f <= 1'b0;
    end
    assign flag_o[g] = f;
  end
endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
  import nvm_pkg::*;
#(
  parameter int AW    = 8,
  parameter int PW    = 4,
  parameter int PAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic [AW-1:0]     prog_addr,
  input  logic [15:0]       prog_data,
  input  logic              start_page_erase,
  input  logic              start_mass_erase,
  input  logic [AW-PW-1:0]  erase_page,
  input  logic [PAGES-1:0]  page_wp,
  input  logic [15:0]       arr_rdata,
  input  logic              arr_done,
  output logic              busy,
  output logic              erasing,
  output logic [AW-1:0]     op_addr,
  output logic [15:0]       op_data,
  output logic              arr_prog,
  output logic              arr_erase,
  output logic              set_eop,
  output logic              set_pgerr,
  output logic              set_wperr,
  output logic              addr_ld,
  output logic [AW-1:0]     addr_val
);
  localparam int PGW       = AW - PW;
  localparam int PAGE_SPAN = 2 ** PGW;

  op_state_t            state;
  logic [AW-1:0]        addr_q;
  logic [15:0]          data_q;
  logic                 mass_q;
  logic                 kind_erase_q;
  logic [PAGE_SPAN-1:0] prot_map;
  logic                 prog_prot, erase_prot, blank, last_page, step;
  logic [AW-1:0]        next_base;

  // pages beyond the user area (information page and unused codes) are protected
  assign prot_map   = {{(PAGE_SPAN-PAGES){1'b1}}, page_wp};
  assign prog_prot  = prot_map[prog_addr[AW-1:PW]];
  assign erase_prot = prot_map[erase_page];
  assign blank      = (arr_rdata == ERASED_HW);
  assign last_page  = (addr_q[AW-1:PW] == PGW'(PAGES-1));
  assign next_base  = {addr_q[AW-1:PW] + PGW'(1), {PW{1'b0}}};
  assign step       = (state == OP_WAIT) && arr_done && mass_q && !last_page;

  always_comb begin
    arr_prog  = (state == OP_CHECK) && blank;
    arr_erase = (state == OP_ERASE);
    set_pgerr = (state == OP_CHECK) && !blank;
    set_eop   = (state == OP_WAIT) && arr_done && !step;
    set_wperr = (state == OP_IDLE) &&
                ((start_prog && prog_prot) || (!start_prog && start_page_erase && erase_prot));
    addr_ld   = 1'b0;
    addr_val  = addr_q;
    if (state == OP_IDLE) begin
      if (start_prog) begin
        addr_ld  = 1'b1;
        addr_val = prog_addr;
      end else if (!start_page_erase && start_mass_erase) begin
        addr_ld  = 1'b1;
        addr_val = '0;
      end
    end else if (step) begin
      addr_ld  = 1'b1;
      addr_val = next_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= OP_IDLE;
      addr_q       <= '0;
      data_q       <= '0;
      mass_q       <= 1'b0;
      kind_erase_q <= 1'b0;
    end else begin
      unique case (state)
        OP_IDLE: begin
          if (start_prog) begin
            addr_q       <= prog_addr;
            data_q       <= prog_data;
            mass_q       <= 1'b0;
            kind_erase_q <= 1'b0;
            if (!prog_prot) state <= OP_CHECK;
          end else if (start_page_erase) begin
            if (!erase_prot) begin
              addr_q       <= {erase_page, {PW{1'b0}}};
              mass_q       <= 1'b0;
              kind_erase_q <= 1'b1;
              state        <= OP_ERASE;
            end
          end else if (start_mass_erase) begin
            addr_q       <= '0;
            mass_q       <= 1'b1;
            kind_erase_q <= 1'b1;
            state        <= OP_ERASE;
          end
        end
        OP_CHECK: state <= blank ? OP_WAIT : OP_IDLE;
        OP_ERASE: state <= OP_WAIT;
        OP_WAIT: begin
          if (arr_done) begin
            if (step) begin
              addr_q <= next_base;
              state  <= OP_ERASE;
            end else begin
              state  <= OP_IDLE;
            end
          end
        end
        default: state <= OP_IDLE;
      endcase
    end
  end

  assign busy    = (state != OP_IDLE);
  assign erasing = busy && kind_erase_q;
  assign op_addr = addr_q;
  assign op_data = data_q;
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int PAGES   = 8,
  parameter int PAGE_HW = 16,
  localparam int PW     = $clog2(PAGE_HW),
  localparam int AW     = $clog2((PAGES + 1) * PAGE_HW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             reg_ready,
  output logic [31:0]      reg_rdata,
  input  logic             mem_valid,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_addr,
  input  logic [15:0]      mem_wdata,
  output logic             mem_ready,
  output logic [15:0]      mem_rdata,
  input  logic [PAGES-1:0] page_wp,
  output logic [AW-1:0]    arr_addr,
  output logic [15:0]      arr_wdata,
  output logic             arr_prog,
  output logic             arr_erase,
  input  logic [15:0]      arr_rdata,
  input  logic             arr_done,
  output logic             irq_eop,
  output logic             irq_err
);
  logic          reg_wr, wr_key, wr_stat, wr_ctrl, wr_addr, ctrl_wr_ok;
  logic          locked, relock, busy, erasing;
  logic          pg_q, per_q, mer_q, errie_q, eopie_q;
  logic          start_prog, start_pe, start_me;
  logic [AW-1:0] addr_q, op_addr, addr_val;
  logic          addr_ld;
  logic          set_eop, set_pgerr, set_wperr;
  logic [2:0]    flags;
  logic          eop_flag, wperr_flag, pgerr_flag;

  assign reg_ready  = 1'b1;
  assign reg_wr     = reg_valid && reg_we;
  assign wr_key     = reg_wr && (reg_addr == RA_KEY);
  assign wr_stat    = reg_wr && (reg_addr == RA_STAT);
  assign wr_ctrl    = reg_wr && (reg_addr == RA_CTRL);
  assign wr_addr    = reg_wr && (reg_addr == RA_ADDR);
  assign ctrl_wr_ok = wr_ctrl && !locked && !busy;
  assign relock     = ctrl_wr_ok && reg_wdata[CB_LOCK];

  nvm_key_gate u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (wr_key),
    .key_data (reg_wdata),
    .relock   (relock),
    .locked   (locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q    <= 1'b0;
      per_q   <= 1'b0;
      mer_q   <= 1'b0;
      errie_q <= 1'b0;
      eopie_q <= 1'b0;
    end else if (ctrl_wr_ok) begin
      pg_q    <= reg_wdata[CB_PG];
      per_q   <= reg_wdata[CB_PER];
      mer_q   <= reg_wdata[CB_MER];
      errie_q <= reg_wdata[CB_ERRIE];
      eopie_q <= reg_wdata[CB_EOPIE];
    end
  end

  assign start_prog = mem_valid && mem_we && !busy && pg_q;
  assign start_pe   = ctrl_wr_ok && reg_wdata[CB_STRT] && reg_wdata[CB_PER] && !start_prog;
  assign start_me   = ctrl_wr_ok && reg_wdata[CB_STRT] && reg_wdata[CB_MER] &&
                      !reg_wdata[CB_PER] && !start_prog;

  nvm_op_seq #(.AW(AW), .PW(PW), .PAGES(PAGES)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_prog       (start_prog),
    .prog_addr        (mem_addr),
    .prog_data        (mem_wdata),
    .start_page_erase (start_pe),
    .start_mass_erase (start_me),
    .erase_page       (addr_q[AW-1:PW]),
    .page_wp          (page_wp),
    .arr_rdata        (arr_rdata),
    .arr_done         (arr_done),
    .busy             (busy),
    .erasing          (erasing),
    .op_addr          (op_addr),
    .op_data          (arr_wdata),
    .arr_prog         (arr_prog),
    .arr_erase        (arr_erase),
    .set_eop          (set_eop),
    .set_pgerr        (set_pgerr),
    .set_wperr        (set_wperr),
    .addr_ld          (addr_ld),
    .addr_val         (addr_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                addr_q <= '0;
    else if (addr_ld)          addr_q <= addr_val;
    else if (wr_addr && !busy) addr_q <= reg_wdata[AW-1:0];
  end

  nvm_w1c_flags #(.N(3)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({set_eop, set_wperr, set_pgerr}),
    .clr_i  (wr_stat ? {reg_wdata[SB_EOP], reg_wdata[SB_WPERR], reg_wdata[SB_PGERR]} : 3'b000),
    .flag_o (flags)
  );
  assign {eop_flag, wperr_flag, pgerr_flag} = flags;

  assign mem_ready = !busy;
  assign mem_rdata = arr_rdata;
  assign arr_addr  = busy ? op_addr : mem_addr;

  always_comb begin
    unique case (reg_addr)
      RA_STAT: reg_rdata = {26'd0, eop_flag, wperr_flag, 1'b0, pgerr_flag, 1'b0, busy};
      RA_CTRL: reg_rdata = {19'd0, eopie_q, 1'b0, errie_q, 2'b00, locked, erasing,
                            3'b000, mer_q, per_q, pg_q};
      RA_ADDR: reg_rdata = {{(32-AW){1'b0}}, addr_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  assign irq_eop = eop_flag && eopie_q;
  assign irq_err = errie_q && (pgerr_flag || wperr_flag);
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_valid,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       mem_valid,
  input logic       mem_we,
  input logic       mem_ready,
  input logic       busy,
  input logic       locked,
  input logic       pg_q,
  input logic       per_q,
  input logic       mer_q,
  input logic       eop_flag,
  input logic       arr_prog,
  input logic       arr_erase
);
  // R2: a locked block keeps its command bits across a control write
  p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_valid && reg_we && reg_addr == 2'd2) |=>
      ($stable(pg_q) && $stable(per_q) && $stable(mer_q)));

  // R7: the memory bus is held off for the whole operation
  p_stall_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_ready);

  // R4: success flag only rises at the end of a running operation
  p_eop_after_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop_flag) |-> $past(busy));

  // R4: an operation only starts from a bus write
  p_start_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past((mem_valid && mem_we) || (reg_valid && reg_we)));

  // R8: program and erase strobes never overlap
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_prog && arr_erase));

  // R9: strobes only appear inside an operation
  p_strobe_in_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase) |-> busy);
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .mem_valid (mem_valid),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .busy      (busy),
  .locked    (locked),
  .pg_q      (pg_q),
  .per_q     (per_q),
  .mer_q     (mer_q),
  .eop_flag  (eop_flag),
  .arr_prog  (arr_prog),
  .arr_erase (arr_erase)
);

// File: tb/nvm_prog_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_prog_ctrl_tb;
  localparam int PAGES   = 8;
  localparam int PAGE_HW = 16;
  localparam int PW      = $clog2(PAGE_HW);
  localparam int AW      = $clog2((PAGES + 1) * PAGE_HW);
  localparam int TOTAL   = (PAGES + 1) * PAGE_HW;
  localparam int NVEC    = 7;

  // {addr, data, expected status, expected readback}
  localparam logic [45:0] VEC [0:NVEC-1] = '{
    {8'h20, 16'h1234, 6'h20, 16'h1234},
    {8'h20, 16'h5555, 6'h04, 16'h1234},
    {8'h05, 16'hAAAA, 6'h10, 16'hFFFF},
    {8'h8F, 16'h0000, 6'h10, 16'hC08F},
    {8'h3F, 16'hFFFF, 6'h20, 16'hFFFF},
    {8'h3F, 16'h0000, 6'h20, 16'h0000},
    {8'h70, 16'hBEEF, 6'h20, 16'hBEEF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic reg_ready;
  logic [31:0] reg_rdata;
  logic mem_valid = 1'b0, mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [15:0] mem_wdata = 16'd0;
  logic mem_ready;
  logic [15:0] mem_rdata;
  logic [PAGES-1:0] page_wp = 8'h01;
  logic [AW-1:0] arr_addr;
  logic [15:0] arr_wdata, arr_rdata;
  logic arr_prog, arr_erase, arr_done;
  logic irq_eop, irq_err;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  nvm_prog_ctrl #(.PAGES(PAGES), .PAGE_HW(PAGE_HW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .page_wp(page_wp),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_prog(arr_prog), .arr_erase(arr_erase),
    .arr_rdata(arr_rdata), .arr_done(arr_done),
    .irq_eop(irq_eop), .irq_err(irq_err)
  );

  // behavioural array: user pages blank except word 0, information page patterned
  logic [15:0] m [0:TOTAL-1];
  int          cnt;
  logic        kind_erase;
  int          pa;
  logic [15:0] pd;
  logic        done_r;

  assign arr_rdata = (int'(arr_addr) < TOTAL) ? m[arr_addr] : 16'h0000;
  assign arr_done  = done_r;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++)
        m[i] <= (i >= PAGES * PAGE_HW) ? (16'hC000 | 16'(i)) : 16'hFFFF;
      m[0]   <= 16'h0BAD;
      cnt    <= 0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (arr_prog) begin
        cnt <= 3; kind_erase <= 1'b0; pa <= int'(arr_addr); pd <= arr_wdata;
      end else if (arr_erase) begin
        cnt <= 3; kind_erase <= 1'b1; pa <= int'(arr_addr);
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          done_r <= 1'b1;
          if (!kind_erase) m[pa] <= pd;
          else for (int j = 0; j < PAGE_HW; j++) m[(pa & ~(PAGE_HW-1)) + j] <= 16'hFFFF;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mem_wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    mem_valid = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    while (!mem_ready) @(negedge clk);
    @(negedge clk);
    mem_valid = 1'b0; mem_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [AW-1:0] a, output logic [15:0] d, output int stalls);
    stalls = 0;
    @(negedge clk);
    mem_valid = 1'b1; mem_we = 1'b0; mem_addr = a;
    while (!mem_ready) begin
      stalls++;
      @(negedge clk);
    end
    #1 d = mem_rdata;
    @(negedge clk);
    mem_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      reg_rd(2'd1, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic unlock();
    reg_wr(2'd0, 32'h4567_0123);
    reg_wr(2'd0, 32'hCDEF_89AB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] h;
    int st;

    do_reset();
    reg_rd(2'd2, r); chk("R1 ctrl reset", r, 32'h80);
    reg_rd(2'd1, r); chk("R1 stat reset", r, 32'h0);
    chk("R1 irq reset", {30'd0, irq_eop, irq_err}, 32'h0);

    reg_wr(2'd2, 32'h1401);
    reg_rd(2'd2, r); chk("R2 locked ctrl write ignored", r, 32'h80);

    reg_wr(2'd0, 32'h1111_1111); unlock(); reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, r); chk("R3 wrong key lockout", r, 32'h80);
    do_reset();
    reg_wr(2'd0, 32'hCDEF_89AB); unlock(); reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, r); chk("R3 out-of-order lockout", r, 32'h80);
    do_reset();

    unlock(); reg_wr(2'd2, 32'h1400);
    reg_rd(2'd2, r); chk("R2 unlocked ctrl write", r, 32'h1400);

    mem_wr(8'h40, 16'h1111); wait_idle();
    mem_rd(8'h40, h, st); chk("R12 write without PG ignored", {16'd0, h}, 32'hFFFF);
    reg_rd(2'd1, r); chk("R12 no status", r, 32'h0);

    reg_wr(2'd2, 32'h1401);
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  va;
      logic [15:0] vd, vr;
      logic [5:0]  vs;
      {va, vd, vs, vr} = VEC[v];
      reg_wr(2'd1, 32'h34);
      mem_wr(va, vd);
      chk("R7 ready during op", {31'd0, mem_ready}, {31'd0, vs == 6'h10});
      wait_idle();
      reg_rd(2'd1, r); chk("R4/R5/R6 status", r, {26'd0, vs});
      reg_rd(2'd3, r); chk("R4 address register", r, {24'd0, va});
      mem_rd(va, h, st); chk("R4/R5/R6 readback", {16'd0, h}, {16'd0, vr});
      chk("R11 irq lines", {30'd0, irq_eop, irq_err}, {30'd0, vs[5], vs[4] | vs[2]});
    end

    reg_wr(2'd1, 32'h34);
    mem_wr(8'h71, 16'h7777);
    mem_rd(8'h71, h, st);
    chk("R7 read after stall returns new data", {16'd0, h}, 32'h7777);
    chk("R7 read was stalled", {31'd0, st > 0}, 32'h1);

    reg_wr(2'd1, 32'h34); wait_idle();
    mem_wr(8'h71, 16'h0000); wait_idle();
    reg_wr(2'd1, 32'h0);
    reg_rd(2'd1, r); chk("R10 write zero keeps flag", r, 32'h04);
    chk("R11 irq_err on PGERR", {31'd0, irq_err}, 32'h1);
    reg_wr(2'd1, 32'h04);
    reg_rd(2'd1, r); chk("R10 write one clears", r, 32'h0);
    chk("R11 irq_err cleared", {31'd0, irq_err}, 32'h0);

    reg_wr(2'd2, 32'h0401);
    mem_wr(8'h72, 16'h2222); wait_idle();
    reg_rd(2'd1, r); chk("R4 eop set", r, 32'h20);
    chk("R11 irq_eop masked", {31'd0, irq_eop}, 32'h0);
    reg_wr(2'd2, 32'h1401);
    chk("R11 irq_eop enabled", {31'd0, irq_eop}, 32'h1);
    reg_wr(2'd1, 32'h34);

    mem_wr(8'h50, 16'h0001); wait_idle();
    reg_wr(2'd1, 32'h34);
    reg_wr(2'd3, 32'h55);
    reg_wr(2'd2, 32'h1442);
    reg_rd(2'd2, r); chk("R8 STRT high while erasing", r, 32'h1442);
    wait_idle();
    reg_rd(2'd2, r); chk("R8 STRT cleared", r, 32'h1402);
    mem_rd(8'h50, h, st); chk("R8 page first word erased", {16'd0, h}, 32'hFFFF);
    mem_rd(8'h5F, h, st); chk("R8 page last word erased", {16'd0, h}, 32'hFFFF);
    mem_rd(8'h20, h, st); chk("R8 other page kept", {16'd0, h}, 32'h1234);
    reg_rd(2'd1, r); chk("R8 eop", r, 32'h20);

    reg_wr(2'd1, 32'h34);
    reg_wr(2'd3, 32'h03);
    reg_wr(2'd2, 32'h1442);
    reg_rd(2'd1, r); chk("R6 protected erase refused", r, 32'h10);
    reg_rd(2'd2, r); chk("R6 STRT stays low", r, 32'h1402);
    mem_rd(8'h00, h, st); chk("R6 protected page kept", {16'd0, h}, 32'h0BAD);

    reg_wr(2'd1, 32'h34);
    reg_wr(2'd2, 32'h1444); wait_idle();
    mem_rd(8'h00, h, st); chk("R9 protected page mass erased", {16'd0, h}, 32'hFFFF);
    mem_rd(8'h20, h, st); chk("R9 page 2 erased", {16'd0, h}, 32'hFFFF);
    mem_rd(8'h70, h, st); chk("R9 last page erased", {16'd0, h}, 32'hFFFF);
    mem_rd(8'h8F, h, st); chk("R9 information page kept", {16'd0, h}, 32'hC08F);
    reg_rd(2'd3, r); chk("R9 address after mass erase", r, 32'h70);
    reg_rd(2'd1, r); chk("R9 eop", r, 32'h20);

    reg_wr(2'd2, 32'h0480);
    reg_rd(2'd2, r); chk("R2 relock", r, 32'h480);
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, r); chk("R2 relocked write ignored", r, 32'h480);
    unlock(); reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, r); chk("R2 unlock after relock", r, 32'h1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule